// File: doc/BRIEF.md
# Byte Write Strobe Decoder

This block turns the write controls of a synchronous memory port into per-lane write strobes. The data word is split into lanes of nine bits each: four lanes in the wide configuration, two in the narrow one. Every control input is active low. A whole-word write input selects every lane at once. A lane-gate input decides whether the per-lane write selects are looked at at all. A cycle-valid qualifier comes from the access decoder, and a processor-start flag marks cycles that the processor address strobe opened.

The decoder samples these controls on the rising clock edge. On that same edge it registers one write strobe per lane, alongside the address and input data held elsewhere, so the array can finish a self-timed write within the following cycle. It registers a driver-off signal on the same edge, and that signal turns the data output drivers off whenever any lane is being written. A cycle the processor strobe opened is always a read, whatever the write controls say. The lane count is a parameter, and the narrow configuration ignores the two upper lane selects.

Top module: `byte_write_decoder`

## Requirements
- R1: While reset is asserted, every lane strobe and the driver-off output are 0.
- R2: In a valid cycle without processor start and with the whole-word write low, every configured lane strobe is 1 after the next rising edge, whatever the lane gate and lane selects are.
- R3: In a valid cycle without processor start, with the whole-word write high and the lane gate low, lane strobe i after the next edge equals the inverse of lane select bit i. Bit i of the select and strobe vectors belongs to lane i.
- R4: In a valid cycle without processor start, with the whole-word write high and the lane gate high, all strobes are 0 after the next edge, whatever the lane selects are.
- R5: In a cycle with processor start high, all strobes and the driver-off output are 0 after the next edge, whatever the write controls are.
- R6: In a cycle with the cycle-valid input low, all strobes and the driver-off output are 0 after the next edge.
- R7: The driver-off output is 1 in exactly those cycles in which at least one lane strobe is 1.
- R8: With two lanes configured, lane selects 3 and 2 have no effect and strobes 3 and 2 stay 0.
- R9: Strobes last one cycle only. After a read or idle cycle, every strobe is 0 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cyc_vld_i | input | 1 | The access decoder has accepted a cycle |
| proc_start_i | input | 1 | The processor address strobe opened this cycle (forces a read) |
| all_wr_ni | input | 1 | Whole-word write, active low |
| lane_gate_ni | input | 1 | Lets the lane selects through when low |
| lane_wr_ni | input | 4 | Per-lane write selects, active low, bit i for lane i |
| lane_stb_o | output | 4 | Registered per-lane write strobes, active high |
| drv_off_o | output | 1 | Registered data-driver disable |

## Verification
Two things can fall in one cycle and pull against each other. The first is a processor-start read arriving while the whole-word write or the gated lane selects are active. The second is a whole-word write arriving while the lane gate and a partial lane pattern are also active. Directed cycles force both overlaps, and random stimulus hits them often. The check is made one edge later: the processor-start case must give no strobe and the drivers left on, and the whole-word case must give every configured strobe regardless of the lane pattern. A narrow instance driven with the same stimulus confirms that the upper lanes never respond.

// File: rtl/bwd_pkg.sv
package bwd_pkg;

   localparam int unsigned MAX_LANES = 4;

   typedef enum logic [1:0] {
      CYC_IDLE   = 2'd0,
      CYC_READ   = 2'd1,
      CYC_GLOBAL = 2'd2,
      CYC_LANE   = 2'd3
   } cyc_kind_e;

   // Mask of the configured lanes within the fixed-width port
   function automatic logic [MAX_LANES-1:0] lane_mask(input int unsigned n);
      logic [MAX_LANES-1:0] m;
      for (int i = 0; i < MAX_LANES; i++) m[i] = (i < n);
      return m;
   endfunction

endpackage

// File: rtl/bwd_cycle_class.sv
module bwd_cycle_class
   import bwd_pkg::*;
#(
   parameter int unsigned NUM_LANES = 4
) (
   input  logic                 cyc_vld_i,
   input  logic                 proc_start_i,
   input  logic                 all_wr_ni,
   input  logic                 lane_gate_ni,
   input  logic [MAX_LANES-1:0] lane_wr_ni,
   output cyc_kind_e            kind_o
);
   localparam logic [MAX_LANES-1:0] EN_MASK = lane_mask(NUM_LANES);

   logic any_lane_sel;
   assign any_lane_sel = |(~lane_wr_ni & EN_MASK);

   always_comb begin
      if (!cyc_vld_i)                        kind_o = CYC_IDLE;
      else if (proc_start_i)                 kind_o = CYC_READ;
      else if (!all_wr_ni)                   kind_o = CYC_GLOBAL;
      else if (!lane_gate_ni && any_lane_sel) kind_o = CYC_LANE;
      else                                   kind_o = CYC_READ;
   end
endmodule

// File: rtl/bwd_lane_gate.sv
module bwd_lane_gate
   import bwd_pkg::*;
#(
   parameter int unsigned NUM_LANES = 4
) (
   input  cyc_kind_e            kind_i,
   input  logic [MAX_LANES-1:0] lane_wr_ni,
   output logic [MAX_LANES-1:0] lane_req_o,
   output logic                 any_wr_o
);
   for (genvar g = 0; g < MAX_LANES; g++) begin : g_lane
      if (g < NUM_LANES) begin : g_live
         always_comb begin
            unique case (kind_i)
               CYC_GLOBAL: lane_req_o[g] = 1'b1;
               CYC_LANE:   lane_req_o[g] = ~lane_wr_ni[g];
               default:    lane_req_o[g] = 1'b0;
            endcase
         end
      end else begin : g_absent
         assign lane_req_o[g] = 1'b0;
      end
   end

   assign any_wr_o = (kind_i == CYC_GLOBAL) || (kind_i == CYC_LANE);
endmodule

// File: rtl/bwd_stb_reg.sv
module bwd_stb_reg
   import bwd_pkg::*;
(
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic [MAX_LANES-1:0] lane_req_i,
   input  logic                 any_wr_i,
   output logic [MAX_LANES-1:0] lane_stb_o,
   output logic                 drv_off_o
);
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         lane_stb_o <= '0;
         drv_off_o  <= 1'b0;
      end else begin
         lane_stb_o <= lane_req_i;
         drv_off_o  <= any_wr_i;
      end
   end
endmodule

// File: rtl/byte_write_decoder.sv
module byte_write_decoder
   import bwd_pkg::*;
#(
   parameter int unsigned NUM_LANES = 4
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 cyc_vld_i,
   input  logic                 proc_start_i,
   input  logic                 all_wr_ni,
   input  logic                 lane_gate_ni,
   input  logic [MAX_LANES-1:0] lane_wr_ni,
   output logic [MAX_LANES-1:0] lane_stb_o,
   output logic                 drv_off_o
);
   if (NUM_LANES != 2 && NUM_LANES != 4) begin : g_bad_cfg
      $error("byte_write_decoder: NUM_LANES must be 2 or 4");
   end

   cyc_kind_e            kind;
   logic [MAX_LANES-1:0] lane_req;
   logic                 any_wr;

   bwd_cycle_class #(.NUM_LANES(NUM_LANES)) u_class (
      .cyc_vld_i    (cyc_vld_i),
      .proc_start_i (proc_start_i),
      .all_wr_ni    (all_wr_ni),
      .lane_gate_ni (lane_gate_ni),
      .lane_wr_ni   (lane_wr_ni),
      .kind_o       (kind)
   );

   bwd_lane_gate #(.NUM_LANES(NUM_LANES)) u_gate (
      .kind_i     (kind),
      .lane_wr_ni (lane_wr_ni),
      .lane_req_o (lane_req),
      .any_wr_o   (any_wr)
   );

   bwd_stb_reg u_reg (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .lane_req_i (lane_req),
      .any_wr_i   (any_wr),
      .lane_stb_o (lane_stb_o),
      .drv_off_o  (drv_off_o)
   );
endmodule

// File: rtl/bwd_chk.sv
module bwd_chk
   import bwd_pkg::*;
#(
   parameter int unsigned NUM_LANES = 4
) (
   input logic                 clk_i,
   input logic                 rst_ni,
   input logic                 cyc_vld_i,
   input logic                 proc_start_i,
   input logic                 all_wr_ni,
   input logic                 lane_gate_ni,
   input logic [MAX_LANES-1:0] lane_wr_ni,
   input logic [MAX_LANES-1:0] lane_stb_o,
   input logic                 drv_off_o
);
   localparam logic [MAX_LANES-1:0] EN = lane_mask(NUM_LANES);

   always_comb begin
      if (!rst_ni) a_r1_reset_quiet: assert (lane_stb_o == '0 && !drv_off_o);
   end

   a_r2_global_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cyc_vld_i && !proc_start_i && !all_wr_ni) |=> (lane_stb_o == EN));

   a_r3_lane_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cyc_vld_i && !proc_start_i && all_wr_ni && !lane_gate_ni)
      |=> (lane_stb_o == (~$past(lane_wr_ni) & EN)));

   a_r4_gate_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cyc_vld_i && !proc_start_i && all_wr_ni && lane_gate_ni) |=> (lane_stb_o == '0));

   a_r5_proc_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cyc_vld_i && proc_start_i) |=> (lane_stb_o == '0 && !drv_off_o));

   a_r6_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cyc_vld_i |=> (lane_stb_o == '0 && !drv_off_o));

   a_r7_drv_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
      drv_off_o == (|lane_stb_o));

   a_r8_narrow: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lane_stb_o & ~EN) == '0);
endmodule

bind byte_write_decoder bwd_chk #(.NUM_LANES(NUM_LANES)) u_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .cyc_vld_i    (cyc_vld_i),
   .proc_start_i (proc_start_i),
   .all_wr_ni    (all_wr_ni),
   .lane_gate_ni (lane_gate_ni),
   .lane_wr_ni   (lane_wr_ni),
   .lane_stb_o   (lane_stb_o),
   .drv_off_o    (drv_off_o)
);

// File: tb/tb_byte_write_decoder.sv
module tb_byte_write_decoder;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       vld = 1'b0, ps = 1'b0, gw_n = 1'b1, gate_n = 1'b1;
   logic [3:0] sel_n = 4'hF;
   logic [3:0] stb4, stb2;
   logic       off4, off2;
   int         n_chk = 0, n_fail = 0;
   bit         done = 1'b0;

   always #4 clk = ~clk;

   byte_write_decoder #(.NUM_LANES(4)) dut (
      .clk_i(clk), .rst_ni(rst_n), .cyc_vld_i(vld), .proc_start_i(ps),
      .all_wr_ni(gw_n), .lane_gate_ni(gate_n), .lane_wr_ni(sel_n),
      .lane_stb_o(stb4), .drv_off_o(off4));

   byte_write_decoder #(.NUM_LANES(2)) dut2 (
      .clk_i(clk), .rst_ni(rst_n), .cyc_vld_i(vld), .proc_start_i(ps),
      .all_wr_ni(gw_n), .lane_gate_ni(gate_n), .lane_wr_ni(sel_n),
      .lane_stb_o(stb2), .drv_off_o(off2));

   function automatic logic [3:0] exp_stb(logic v, logic p, logic g, logic b,
                                          logic [3:0] s, int n);
      logic [3:0] m;
      for (int i = 0; i < 4; i++) m[i] = (i < n);
      if (!v || p)  return 4'h0;
      if (!g)       return m;
      if (!b)       return ~s & m;
      return 4'h0;
   endfunction

   task automatic check(string req, logic [3:0] act, logic [3:0] expv);
      n_chk++;
      if (act !== expv) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, expv);
      end
   endtask

   function automatic string tag_of(logic v, logic p, logic g, logic b);
      if (!v) return "R6";
      if (p)  return "R5";
      if (!g) return "R2";
      if (!b) return "R3";
      return "R4";
   endfunction

   task automatic step(logic v, logic p, logic g, logic b, logic [3:0] s);
      logic [3:0] e4, e2;
      @(negedge clk);
      vld = v; ps = p; gw_n = g; gate_n = b; sel_n = s;
      e4 = exp_stb(v, p, g, b, s, 4);
      e2 = exp_stb(v, p, g, b, s, 2);
      @(posedge clk); #1;
      check(tag_of(v, p, g, b), stb4, e4);
      check("R7", {3'b0, off4}, {3'b0, |e4});
      check("R8", stb2, e2);
      check("R8 drv", {3'b0, off2}, {3'b0, |e2});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++; n_chk++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd7032));
      // R1: reset state, with write controls active
      vld = 1'b1; gw_n = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      check("R1", stb4, 4'h0);
      check("R1", {3'b0, off4}, 4'h0);
      check("R1", stb2, 4'h0);
      @(negedge clk); rst_n = 1'b1; vld = 1'b0; gw_n = 1'b1;

      // Directed corners
      step(1, 0, 0, 0, 4'b1010);   // R2 global overrides lane pattern
      step(1, 0, 0, 1, 4'b1111);   // R2 global with gate high
      step(1, 0, 1, 0, 4'b1010);   // R3 lanes 0,2
      step(1, 0, 1, 0, 4'b0111);   // R3 lane 3 only; narrow must stay 0 (R8)
      step(1, 0, 1, 0, 4'b1111);   // R3 no lane selected -> read
      step(1, 0, 1, 1, 4'b0000);   // R4 gate blocks all lanes
      step(1, 1, 0, 0, 4'b0000);   // R5 processor start beats global write
      step(1, 1, 1, 0, 4'b0000);   // R5 processor start beats lane writes
      step(0, 0, 0, 0, 4'b0000);   // R6 invalid cycle
      step(1, 0, 0, 0, 4'b0000);   // R2 then R9 drop
      step(1, 0, 1, 1, 4'b1111);   // R9 strobes cleared after read
      step(1, 0, 1, 0, 4'b1100);   // R3 lanes 0,1

      // Random mix
      for (int k = 0; k < 600; k++) begin
         logic [7:0] r;
         r = 8'($urandom);
         step(($urandom % 8) != 0, ($urandom % 5) == 0, r[0] | r[1],
              r[2], 4'($urandom));
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule